// File: doc/BRIEF.md
# Pipeline Hazard Stall and Squash Controller

This block decides, every cycle, whether the decode stage of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) must wait. It also decides which younger instructions a resolved branch throws away. It reads three groups of inputs:

- the source register numbers of the instruction in decode, each with a flag saying whether the operand is really read;
- the destination, write enable and load flag of the instruction in execute, and the destination and write enable of the instruction in memory;
- a branch-resolution strobe with its taken flag.

From these it drives five outputs: a PC hold, a decode-register hold, and squash controls for the fetch, decode and execute pipeline registers. The datapath, the ALU and the bypass multiplexers live elsewhere.

A two-bit policy input selects one of three hazard policies:

- **No-bypass.** The register file writes early in a cycle and reads late in it. A consumer may therefore decode in the same cycle that its producer writes back, and the writeback stage needs no input here. Branches resolve in memory.
- **Bypassed, predict not-taken.** A full bypass network is present and branches resolve in decode.
- **Bypassed, delay slot.** As above, but the instruction after a branch always executes.

The policy input passes through one register before it is used, so a new policy applies from the clock edge that samples it. All pins are plain control pins; there is no data stream and no handshake.

Top module: `hazard_ctrl`

## Requirements
- R1: Policy encoding on `mode_i`: 0 = no-bypass with branches resolved in memory, 1 = bypassed with branches resolved in decode and predicted not-taken, 2 = bypassed with one delay slot, 3 = same as 0. The policy is registered. While `rst_ni` is low it is 0. A new value applies to the outputs only after the rising edge that samples it.
- R2: Under policy 0, a stall is raised when a flagged decode source matches a written, non-zero destination in execute or in memory. A stall means `pc_hold_o`=1, `dec_hold_o`=1, `kill_dec_o`=1 (a bubble enters execute), `kill_fetch_o`=0 and `kill_exe_o`=0.
- R3: Under policy 0, no stall is raised when neither execute nor memory holds a matching written destination. A producer that has reached writeback never stalls decode.
- R4: Under policy 0, a taken branch strobe asserts `kill_fetch_o`, `kill_dec_o` and `kill_exe_o` and clears both holds. A not-taken strobe changes nothing.
- R5: Under policies 1 and 2, a non-load producer in execute, or any producer in memory, never stalls decode.
- R6: Under policies 1 and 2, a load in execute whose destination matches a flagged decode source raises the stall of R2.
- R7: Under policy 1, a taken branch strobe asserts only `kill_fetch_o`. A not-taken strobe changes nothing.
- R8: Under policy 2, a branch strobe never squashes anything, whether taken or not. A stall raised in the same cycle stands.
- R9: Register number 0 never creates a dependency, whether it appears as a source or as a destination.
- R10: Source slot k occupies bits [k*REG_W +: REG_W] of `dec_src_i` and is checked only when bit k of `dec_src_use_i` is 1. Store-data and branch-condition operands are flagged like any other source.
- R11: When a stall and a squash caused by a taken branch fall in the same cycle, the squash wins: both holds are 0 and the squash outputs are as in R4 or R7.
- R12: Policy value 3 behaves exactly as policy 0 for both stalls and squashes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Hazard policy select (see R1) |
| dec_src_i | input | NUM_SRC*REG_W | Source register numbers of the decode instruction |
| dec_src_use_i | input | NUM_SRC | Per-slot flag: source is actually read |
| ex_rd_i | input | REG_W | Destination register of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes its destination |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory instruction |
| mem_wen_i | input | 1 | Memory instruction writes its destination |
| br_valid_i | input | 1 | A branch resolves this cycle |
| br_taken_i | input | 1 | The resolving branch is taken |
| pc_hold_o | output | 1 | Keep the PC unchanged |
| dec_hold_o | output | 1 | Keep the fetch/decode register unchanged |
| kill_fetch_o | output | 1 | Load a no-op into the fetch/decode register |
| kill_dec_o | output | 1 | Load a bubble into the decode/execute register |
| kill_exe_o | output | 1 | Load a bubble into the execute/memory register |

## Verification
Each policy is driven with the same pairs of producer and consumer, placed in execute, in memory, and in neither. This separates the no-bypass rule, which stalls on either stage, from the bypassed rules, which stall only on a load in execute. Branch strobes are applied taken and not-taken under every policy, so each policy's squash pattern is told apart from the others. Dependency patterns with register 0, unflagged slots and a match in only one slot show that each slot is masked on its own. Cases where a stall and a taken branch coincide, together with a policy change observed on both sides of its sampling edge, confirm the priority order and the one-edge latency.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    HZ_NOBYP    = 2'd0,
    HZ_BYP_PNT  = 2'd1,
    HZ_BYP_SLOT = 2'd2,
    HZ_ALIAS    = 2'd3
  } hzd_mode_e;

  typedef struct packed {
    logic fetch;
    logic dec;
    logic exe;
  } hzd_kill_t;

  // Late-resolving, non-bypassed policy (value 3 aliases value 0)
  function automatic logic hzd_is_late(hzd_mode_e m);
    return (m == HZ_NOBYP) || (m == HZ_ALIAS);
  endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]       use_i,
  input  logic [REG_W-1:0]         rd_i,
  input  logic                     wen_i,
  output logic                     hit_o
);

  logic [NUM_SRC-1:0] slot_hit;
  logic               rd_live;

  // A destination of zero never produces anything
  assign rd_live = wen_i && (rd_i != '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    logic [REG_W-1:0] slot_reg;
    assign slot_reg    = src_i[k*REG_W +: REG_W];
    assign slot_hit[k] = use_i[k] && (slot_reg != '0) && rd_live && (slot_reg == rd_i);
  end

  assign hit_o = |slot_hit;

endmodule

// File: rtl/hzd_stall_pol.sv
module hzd_stall_pol
  import hzd_pkg::*;
(
  input  hzd_mode_e mode_i,
  input  logic      hit_ex_i,
  input  logic      hit_mem_i,
  input  logic      ex_load_i,
  output logic      stall_o
);

  always_comb begin
    unique case (mode_i)
      HZ_BYP_PNT,
      HZ_BYP_SLOT: stall_o = hit_ex_i && ex_load_i;   // only load-use waits
      default:     stall_o = hit_ex_i || hit_mem_i;   // wait until writeback
    endcase
  end

endmodule

// File: rtl/hzd_redirect_pol.sv
module hzd_redirect_pol
  import hzd_pkg::*;
(
  input  hzd_mode_e mode_i,
  input  logic      br_valid_i,
  input  logic      br_taken_i,
  output hzd_kill_t kill_o
);

  logic taken;
  assign taken = br_valid_i && br_taken_i;

  always_comb begin
    kill_o = '0;
    if (hzd_is_late(mode_i)) begin
      // branch sits in memory: three younger instructions are wrong-path
      kill_o.fetch = taken;
      kill_o.dec   = taken;
      kill_o.exe   = taken;
    end else if (mode_i == HZ_BYP_PNT) begin
      kill_o.fetch = taken;
    end
    // delay-slot policy: the following instruction always completes
  end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [NUM_SRC*REG_W-1:0] dec_src_i,
  input  logic [NUM_SRC-1:0]       dec_src_use_i,
  input  logic [REG_W-1:0]         ex_rd_i,
  input  logic                     ex_wen_i,
  input  logic                     ex_load_i,
  input  logic [REG_W-1:0]         mem_rd_i,
  input  logic                     mem_wen_i,
  input  logic                     br_valid_i,
  input  logic                     br_taken_i,
  output logic                     pc_hold_o,
  output logic                     dec_hold_o,
  output logic                     kill_fetch_o,
  output logic                     kill_dec_o,
  output logic                     kill_exe_o
);

  localparam int NUM_STG = 2;   // stages compared: 0 = execute, 1 = memory

  hzd_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= HZ_NOBYP;
    else         mode_q <= hzd_mode_e'(mode_i);
  end

  logic [NUM_STG-1:0][REG_W-1:0] stg_rd;
  logic [NUM_STG-1:0]            stg_wen;
  logic [NUM_STG-1:0]            stg_hit;

  assign stg_rd  = {mem_rd_i, ex_rd_i};
  assign stg_wen = {mem_wen_i, ex_wen_i};

  for (genvar s = 0; s < NUM_STG; s++) begin : g_stage
    hzd_src_cmp #(
      .REG_W   (REG_W),
      .NUM_SRC (NUM_SRC)
    ) u_cmp (
      .src_i (dec_src_i),
      .use_i (dec_src_use_i),
      .rd_i  (stg_rd[s]),
      .wen_i (stg_wen[s]),
      .hit_o (stg_hit[s])
    );
  end

  logic      stall_req;
  hzd_kill_t br_kill;

  hzd_stall_pol u_stall (
    .mode_i    (mode_q),
    .hit_ex_i  (stg_hit[0]),
    .hit_mem_i (stg_hit[1]),
    .ex_load_i (ex_load_i),
    .stall_o   (stall_req)
  );

  hzd_redirect_pol u_redir (
    .mode_i     (mode_q),
    .br_valid_i (br_valid_i),
    .br_taken_i (br_taken_i),
    .kill_o     (br_kill)
  );

  logic squash_any;
  logic stall_eff;

  assign squash_any = |br_kill;
  assign stall_eff  = stall_req && !squash_any;   // squash outranks stall

  assign pc_hold_o    = stall_eff;
  assign dec_hold_o   = stall_eff;
  assign kill_fetch_o = br_kill.fetch;
  assign kill_dec_o   = br_kill.dec || stall_eff;
  assign kill_exe_o   = br_kill.exe;

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [1:0]       mode_q,
  input logic [REG_W-1:0] ex_rd_i,
  input logic             ex_load_i,
  input logic [REG_W-1:0] mem_rd_i,
  input logic             br_valid_i,
  input logic             br_taken_i,
  input logic             pc_hold_o,
  input logic             dec_hold_o,
  input logic             kill_fetch_o,
  input logic             kill_dec_o,
  input logic             kill_exe_o
);

  logic byp_mode;
  logic late_mode;
  assign byp_mode  = (mode_q == HZ_BYP_PNT) || (mode_q == HZ_BYP_SLOT);
  assign late_mode = (mode_q == HZ_NOBYP) || (mode_q == HZ_ALIAS);

  p_mode_lag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (mode_q == $past(mode_i)));

  p_late_squash_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_mode && br_valid_i && br_taken_i) |-> (kill_fetch_o && kill_dec_o && kill_exe_o));

  p_alu_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_mode && !ex_load_i) |-> !pc_hold_o);

  p_early_squash_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == HZ_BYP_PNT) |-> !kill_exe_o);

  p_slot_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == HZ_BYP_SLOT) |-> (!kill_fetch_o && !kill_exe_o));

  p_zero_dest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ex_rd_i == '0) && (mem_rd_i == '0)) |-> !pc_hold_o);

  p_squash_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_fetch_o |-> (!pc_hold_o && !dec_hold_o));

  p_hold_bubble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hold_o |-> (kill_dec_o && !kill_exe_o));

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .mode_q       (mode_q),
  .ex_rd_i      (ex_rd_i),
  .ex_load_i    (ex_load_i),
  .mem_rd_i     (mem_rd_i),
  .br_valid_i   (br_valid_i),
  .br_taken_i   (br_taken_i),
  .pc_hold_o    (pc_hold_o),
  .dec_hold_o   (dec_hold_o),
  .kill_fetch_o (kill_fetch_o),
  .kill_dec_o   (kill_dec_o),
  .kill_exe_o   (kill_exe_o)
);

// File: tb/hazard_ctrl_tb_top.sv
`timescale 1ns/1ps
module hazard_ctrl_tb_top;

  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;
  localparam int NV      = 23;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [1:0]               mode_i = '0;
  logic [NUM_SRC*REG_W-1:0] dec_src_i = '0;
  logic [NUM_SRC-1:0]       dec_src_use_i = '0;
  logic [REG_W-1:0]         ex_rd_i = '0;
  logic                     ex_wen_i = 1'b0;
  logic                     ex_load_i = 1'b0;
  logic [REG_W-1:0]         mem_rd_i = '0;
  logic                     mem_wen_i = 1'b0;
  logic                     br_valid_i = 1'b0;
  logic                     br_taken_i = 1'b0;
  logic pc_hold_o, dec_hold_o, kill_fetch_o, kill_dec_o, kill_exe_o;

  always #2 clk = ~clk;   // 250 MHz

  hazard_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .dec_src_i(dec_src_i), .dec_src_use_i(dec_src_use_i),
    .ex_rd_i(ex_rd_i), .ex_wen_i(ex_wen_i), .ex_load_i(ex_load_i),
    .mem_rd_i(mem_rd_i), .mem_wen_i(mem_wen_i),
    .br_valid_i(br_valid_i), .br_taken_i(br_taken_i),
    .pc_hold_o(pc_hold_o), .dec_hold_o(dec_hold_o),
    .kill_fetch_o(kill_fetch_o), .kill_dec_o(kill_dec_o), .kill_exe_o(kill_exe_o)
  );

  // expected bits: {pc_hold, dec_hold, kill_fetch, kill_dec, kill_exe}
  typedef struct packed {
    logic [1:0] m;
    logic [4:0] s1;
    logic [4:0] s0;
    logic [1:0] u;
    logic [4:0] erd;
    logic       ew;
    logic       el;
    logic [4:0] mrd;
    logic       mw;
    logic       bv;
    logic       bt;
    logic [4:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010, 4'd2},  // R2 EX match
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 5'b11010, 4'd2},  // R2 MEM match
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd3, 1'b0, 1'b0, 5'd9, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd3},  // R3 no write
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd3},  // R3 no match
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b1, 5'b00111, 4'd4},  // R4 taken
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, 5'b00000, 4'd4},  // R4 not taken
    '{2'd1, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd5},  // R5 ALU in EX
    '{2'd2, 5'd4, 5'd3, 2'b11, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd5},  // R5 MEM producer
    '{2'd1, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010, 4'd6},  // R6 load-use
    '{2'd2, 5'd4, 5'd3, 2'b11, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010, 4'd6},  // R6 load-use slot 1
    '{2'd1, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00100, 4'd7},  // R7 taken
    '{2'd1, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 5'b00000, 4'd7},  // R7 not taken
    '{2'd2, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00000, 4'd8},  // R8 taken, slot kept
    '{2'd0, 5'd0, 5'd0, 2'b11, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd9},  // R9 policy 0
    '{2'd1, 5'd0, 5'd0, 2'b11, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd9},  // R9 load to r0
    '{2'd0, 5'd5, 5'd5, 2'b00, 5'd5, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 5'b00000, 4'd10}, // R10 unflagged
    '{2'd0, 5'd6, 5'd2, 2'b10, 5'd6, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b11010, 4'd10}, // R10 slot 1 flagged
    '{2'd0, 5'd6, 5'd2, 2'b01, 5'd6, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd10}, // R10 slot 1 masked
    '{2'd0, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00111, 4'd11}, // R11 late
    '{2'd1, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'b00100, 4'd11}, // R11 early
    '{2'd3, 5'd4, 5'd3, 2'b11, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 1'b0, 5'b11010, 4'd12}, // R12 stall
    '{2'd3, 5'd4, 5'd3, 2'b11, 5'd7, 1'b1, 1'b0, 5'd8, 1'b1, 1'b1, 1'b1, 5'b00111, 4'd12}, // R12 squash
    '{2'd2, 5'd4, 5'd3, 2'b11, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b1, 5'b11010, 4'd8}   // R8 stall stands
  };

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  function automatic logic [4:0] outs();
    return {pc_hold_o, dec_hold_o, kill_fetch_o, kill_dec_o, kill_exe_o};
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i        = v.m;
    dec_src_i     = {v.s1, v.s0};
    dec_src_use_i = v.u;
    ex_rd_i       = v.erd;
    ex_wen_i      = v.ew;
    ex_load_i     = v.el;
    mem_rd_i      = v.mrd;
    mem_wen_i     = v.mw;
    br_valid_i    = v.bv;
    br_taken_i    = v.bt;
  endtask

  // ALU producer of r3 in execute, consumer reads r3 in slot 0
  task automatic set_alu_dep(input logic [1:0] m);
    drive('{m, 5'd0, 5'd3, 2'b01, 5'd3, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'b0, 4'd0});
  endtask

  initial begin
    // R1: reset forces policy 0 even though policy 1 is requested
    set_alu_dep(2'd1);
    repeat (3) @(posedge clk);
    #1 chk(outs(), 5'b11010, "R1 reset policy is no-bypass");
    @(negedge clk) rst_ni = 1'b1;
    #1 chk(outs(), 5'b11010, "R1 policy unchanged before sampling edge");
    @(posedge clk);
    #1 chk(outs(), 5'b00000, "R1 policy 1 after sampling edge");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      @(posedge clk);
      #1 chk(outs(), VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1: one-edge latency of a policy change (last vector left policy 2)
    @(negedge clk);
    set_alu_dep(2'd0);
    #1 chk(outs(), 5'b00000, "R1 old bypass policy still applies");
    @(posedge clk);
    #1 chk(outs(), 5'b11010, "R1 new no-bypass policy applies");

    // R1: reset mid-run returns to policy 0
    @(negedge clk);
    set_alu_dep(2'd2);
    @(posedge clk);
    #1 chk(outs(), 5'b00000, "R1 policy 2 before reset");
    @(negedge clk) rst_ni = 1'b0;
    #1 chk(outs(), 5'b11010, "R1 asynchronous reset to policy 0");
    @(negedge clk) rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-all: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule